// File: doc/BRIEF.md
# Byte-Memory Accumulator Machine with Three-Byte Instruction Fetch

This block is the control sequencer and datapath of a small 8-bit accumulator machine whose memory is byte wide. A memory-reference instruction takes three consecutive bytes: an opcode, then the high byte of a 16-bit operand address, then its low byte. The block reads the opcode into the instruction register. It collects the two address bytes in a 16-bit temporary register and copies that register into the address register. It then reads the 8-bit operand into the data register and applies one of four accumulator operations: load, add, AND, or store. Any other opcode is a one-byte no-operation.

The byte memory is internal. Its contents are written through a preload port, and only while reset is held. A test environment fills memory, releases reset and follows execution. It watches the architectural registers on dedicated outputs and a one-cycle `done_o` pulse that marks the end of every instruction. The address path is 16 bits wide. The stored array has 2**MEM_AW bytes, and address bits at and above MEM_AW are not decoded, so higher addresses alias onto the stored bytes.

Top module: `acc8_core`

## Requirements
- R1: While rst is high and in the first cycle after it falls, pc_o, ar_o, tr_o, ir_o, dr_o and ac_o are 0, step_o is 0 and done_o is 0.
- R2: Each instruction loads the byte at the current PC into ir_o. PC advances by 3 for opcodes 0x01 to 0x04 and by 1 for every other opcode.
- R3: For a memory-reference instruction, the first byte after the opcode becomes tr_o[15:8] and the second becomes tr_o[7:0]. At the end of the instruction, ar_o equals tr_o. Only address bits below MEM_AW (12 by default) select a byte.
- R4: At the end of a memory-reference instruction, dr_o holds the byte stored at the operand address before the instruction executed.
- R5: Opcode 0x01 sets AC to the operand. Opcode 0x02 adds the operand to AC modulo 256. Opcode 0x03 sets AC to AC AND operand. Opcode 0x04 writes AC to the operand address and leaves AC unchanged.
- R6: Any opcode other than 0x01 to 0x04 leaves ac_o, tr_o and dr_o unchanged, and ar_o holds the address of that opcode.
- R7: done_o is high for exactly one cycle per instruction, with step_o equal to 0 in that cycle. Successive pulses are 9 cycles apart after a memory-reference instruction and 3 cycles apart after any other opcode. step_o counts 0 through 8 and never exceeds 8.
- R8: A preload write (ld_we) reaches memory only while rst is high. When rst is low, ld_we has no effect on memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | 16 | Preload byte address |
| ld_data | input | 8 | Preload byte |
| pc_o | output | 16 | Program counter |
| ar_o | output | 16 | Address register |
| tr_o | output | 16 | Temporary address register |
| ir_o | output | 8 | Instruction register |
| dr_o | output | 8 | Data register |
| ac_o | output | 8 | Accumulator |
| step_o | output | 4 | Current timing step, 0 to 8 |
| done_o | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The assertions assume that reset is held for at least one clock before execution begins. They also assume that memory contents change only through the block's own store or through preload under reset. With those assumptions, the step, PC-advance, address-transfer and accumulator-stability properties depend only on the sequencer.

The stimulus preloads every byte under reset. It places operands in a data region that never overlaps the program, so the bench's instruction-by-instruction model stays valid. It pulses ld_we after reset is released only to exercise R8.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW = 8;

  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_ADD   = 8'h02;
  localparam logic [7:0] OPC_AND   = 8'h03;
  localparam logic [7:0] OPC_STORE = 8'h04;

  typedef enum logic [3:0] {
    T0 = 4'd0, T1 = 4'd1, T2 = 4'd2, T3 = 4'd3, T4 = 4'd4,
    T5 = 4'd5, T6 = 4'd6, T7 = 4'd7, T8 = 4'd8
  } step_e;

  function automatic logic is_memref(input logic [7:0] op);
    return (op == OPC_LOAD) || (op == OPC_ADD) || (op == OPC_AND) || (op == OPC_STORE);
  endfunction

  function automatic logic writes_ac(input logic [7:0] op);
    return (op == OPC_LOAD) || (op == OPC_ADD) || (op == OPC_AND);
  endfunction

  function automatic logic [7:0] acc_next(input logic [7:0] op, input logic [7:0] ac,
                                          input logic [7:0] dr);
    logic [7:0] r;
    case (op)
      OPC_LOAD: r = dr;
      OPC_ADD:  r = ac + dr;
      OPC_AND:  r = ac & dr;
      default:  r = ac;
    endcase
    return r;
  endfunction

  function automatic step_e step_next(input step_e s, input logic memref);
    step_e n;
    case (s)
      T8:      n = T0;
      T2:      n = memref ? T3 : T0;
      default: n = step_e'(s + 4'd1);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/acc8_seq.sv
module acc8_seq
  import acc8_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  memref,
  output step_e step,
  output logic  done
);
  logic instr_end;
  assign instr_end = (step == T8) || ((step == T2) && !memref);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= T0;
      done <= 1'b0;
    end else begin
      step <= step_next(step, memref);
      done <= instr_end;
    end
  end
endmodule

// File: rtl/acc8_mem.sv
module acc8_mem #(
  parameter int IW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc8_dp.sv
module acc8_dp
  import acc8_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  step_e         step,
  input  logic [DW-1:0] mrd,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ar,
  output logic [AW-1:0] tr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] dr,
  output logic [DW-1:0] ac,
  output logic          memref,
  output logic          store_we
);
  localparam int HALF = AW / 2;

  logic pc_adv;
  logic ac_load;

  assign memref   = is_memref(ir);
  assign pc_adv   = (step == T1) || (step == T3) || (step == T5);
  assign ac_load  = (step == T8) && writes_ac(ir);
  assign store_we = (step == T8) && (ir == OPC_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ar <= '0;
      tr <= '0;
      ir <= '0;
      dr <= '0;
      ac <= '0;
    end else begin
      if (pc_adv) pc <= pc + AW'(1);
      if (ac_load) ac <= acc_next(ir, ac, dr);
      case (step)
        T0: ar <= pc;
        T1: ir <= mrd;
        T2: if (memref) ar <= pc;
        T3: tr[AW-1:HALF] <= mrd;
        T4: ar <= pc;
        T5: tr[HALF-1:0] <= mrd;
        T6: ar <= tr;
        T7: dr <= mrd;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int AW     = 16,
  parameter int MEM_AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ar_o,
  output logic [AW-1:0] tr_o,
  output logic [7:0]    ir_o,
  output logic [7:0]    dr_o,
  output logic [7:0]    ac_o,
  output logic [3:0]    step_o,
  output logic          done_o
);
  step_e             step;
  logic              memref;
  logic              store_we;
  logic [7:0]        mrd;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  assign mem_we    = rst ? ld_we : store_we;
  assign mem_waddr = rst ? ld_addr[MEM_AW-1:0] : ar_o[MEM_AW-1:0];
  assign mem_wdata = rst ? ld_data : ac_o;
  assign step_o    = step;

  generate
    if (AW > MEM_AW) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^{ld_addr[AW-1:MEM_AW], ar_o[AW-1:MEM_AW]};
    end
  endgenerate

  acc8_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .memref (memref),
    .step   (step),
    .done   (done_o)
  );

  acc8_mem #(.IW(MEM_AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ar_o[MEM_AW-1:0]),
    .rdata (mrd)
  );

  acc8_dp #(.AW(AW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .mrd      (mrd),
    .pc       (pc_o),
    .ar       (ar_o),
    .tr       (tr_o),
    .ir       (ir_o),
    .dr       (dr_o),
    .ac       (ac_o),
    .memref   (memref),
    .store_we (store_we)
  );
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    step_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] ar_o,
  input logic [AW-1:0] tr_o,
  input logic [7:0]    ac_o,
  input logic          done_o
);
  // R7
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    step_o <= 4'd8);

  // R7
  done_at_t0_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (step_o == 4'd0));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o == 4'd1 || step_o == 4'd3 || step_o == 4'd5) |=> (pc_o == $past(pc_o) + AW'(1)));

  // R3
  ar_from_tr_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o == 4'd6) |=> (ar_o == $past(tr_o)));

  // R3
  tr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_o == 4'd3 || step_o == 4'd5) |=> $stable(tr_o));

  // R5
  ac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o != 4'd8) |=> $stable(ac_o));
endmodule

bind acc8_core acc8_core_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .step_o (step_o),
  .pc_o   (pc_o),
  .ar_o   (ar_o),
  .tr_o   (tr_o),
  .ac_o   (ac_o),
  .done_o (done_o)
);

// File: tb/tb_acc8_core.sv
module tb_acc8_core;
  localparam int NB = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [15:0] pc_o, ar_o, tr_o;
  logic [7:0]  ir_o, dr_o, ac_o;
  logic [3:0]  step_o;
  logic        done_o;

  int total = 0;
  int bad = 0;

  logic [7:0]  bmem [NB];
  logic [15:0] m_pc, m_ar, m_tr;
  logic [7:0]  m_ir, m_dr, m_ac;

  always #4 clk = ~clk;

  acc8_core dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .ar_o(ar_o), .tr_o(tr_o), .ir_o(ir_o), .dr_o(dr_o), .ac_o(ac_o),
    .step_o(step_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_memref(input logic [7:0] op);
    return (op >= 8'd1) && (op <= 8'd4);
  endfunction

  function automatic logic [7:0] ref_acc(input logic [7:0] op, input logic [7:0] a,
                                         input logic [7:0] d);
    int s;
    if (op == 8'd1) return d;
    if (op == 8'd2) begin
      s = (int'(a) + int'(d)) % 256;
      return s[7:0];
    end
    if (op == 8'd3) return a & d;
    return a;
  endfunction

  task automatic model_step(output int cyc);
    logic [7:0] hi, lo;
    m_ar = m_pc;
    m_ir = bmem[m_pc[11:0]];
    m_pc = m_pc + 16'd1;
    if (ref_memref(m_ir)) begin
      hi = bmem[m_pc[11:0]];
      m_pc = m_pc + 16'd1;
      lo = bmem[m_pc[11:0]];
      m_pc = m_pc + 16'd1;
      m_tr = {hi, lo};
      m_ar = m_tr;
      m_dr = bmem[m_ar[11:0]];
      if (m_ir == 8'd4) bmem[m_ar[11:0]] = m_ac;
      else m_ac = ref_acc(m_ir, m_ac, m_dr);
      cyc = 9;
    end else begin
      cyc = 3;
    end
  endtask

  task automatic preload_and_reset();
    rst = 1'b1;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 16'(i); ld_data = bmem[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", {16'h0, pc_o}, 32'h0);
    chk("R1 ar/tr", {ar_o, tr_o}, 32'h0);
    chk("R1 ir/dr/ac", {8'h0, ir_o, dr_o, ac_o}, 32'h0);
    chk("R1 step/done", {27'h0, step_o, done_o}, 32'h0);
    m_pc = '0; m_ar = '0; m_tr = '0; m_ir = '0; m_dr = '0; m_ac = '0;
    rst = 1'b0;
  endtask

  task automatic run_instr();
    int n;
    int cyc;
    n = 0;
    do begin
      @(negedge clk);
      ld_we = 1'b0;
      n++;
    end while (!done_o && n < 40);
    model_step(cyc);
    chk("R7 done spacing", n, cyc);
    chk("R7 step at done", {28'h0, step_o}, 32'h0);
    chk("R2 ir", {24'h0, ir_o}, {24'h0, m_ir});
    chk("R2 pc", {16'h0, pc_o}, {16'h0, m_pc});
    chk("R3 tr", {16'h0, tr_o}, {16'h0, m_tr});
    chk("R3 ar", {16'h0, ar_o}, {16'h0, m_ar});
    chk("R4 dr", {24'h0, dr_o}, {24'h0, m_dr});
    if (ref_memref(m_ir)) chk("R5 ac", {24'h0, ac_o}, {24'h0, m_ac});
    else chk("R6 ac", {24'h0, ac_o}, {24'h0, m_ac});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // directed program
    for (int i = 0; i < NB; i++) bmem[i] = 8'($urandom());
    bmem[12'h900] = 8'h5C; bmem[12'h901] = 8'hFF; bmem[12'h902] = 8'h02;
    bmem[12'h903] = 8'h0F; bmem[12'h905] = 8'h77;
    bmem[0]  = 8'h01; bmem[1]  = 8'h09; bmem[2]  = 8'h00;   // load 0x0900
    bmem[3]  = 8'h01; bmem[4]  = 8'h39; bmem[5]  = 8'h01;   // load 0x3901 (alias of 0x901)
    bmem[6]  = 8'h02; bmem[7]  = 8'h09; bmem[8]  = 8'h02;   // add -> wraps to 0x01
    bmem[9]  = 8'h00;                                       // no-op
    bmem[10] = 8'hFF;                                       // no-op
    bmem[11] = 8'h03; bmem[12] = 8'h09; bmem[13] = 8'h03;   // and 0x0F
    bmem[14] = 8'h04; bmem[15] = 8'h09; bmem[16] = 8'h04;   // store 0x0904
    bmem[17] = 8'h01; bmem[18] = 8'h09; bmem[19] = 8'h05;   // load 0x0905
    bmem[20] = 8'h01; bmem[21] = 8'hF9; bmem[22] = 8'h04;   // load 0xF904 (stored byte)
    preload_and_reset();
    // R8: write attempt while running must not reach memory
    ld_we = 1'b1; ld_addr = 16'h0900; ld_data = 8'hAA;
    run_instr();
    chk("R8 ignored preload", {24'h0, ac_o}, 32'h5C);
    for (int k = 1; k < 9; k++) run_instr();
    chk("R5 stored byte reloaded", {24'h0, ac_o}, 32'h01);
    chk("R3 high byte first", {16'h0, tr_o}, 32'hF904);
    @(negedge clk);
    chk("R7 done one cycle", {31'h0, done_o}, 32'h0);

    // random program
    for (int i = 0; i < NB; i++) bmem[i] = 8'($urandom());
    begin
      int a;
      int cnt;
      logic [7:0] op;
      a = 0;
      cnt = 0;
      while (a < 12'h7F0) begin
        if ($urandom_range(0, 9) < 7) begin
          op = 8'($urandom_range(1, 4));
          bmem[a] = op;
          bmem[a+1] = {4'($urandom()), 4'h8};
          bmem[a+2] = 8'($urandom());
          a += 3;
        end else begin
          op = 8'($urandom());
          if (ref_memref(op)) op = 8'h00;
          bmem[a] = op;
          a += 1;
        end
        cnt++;
      end
      preload_and_reset();
      for (int k = 0; k < cnt; k++) run_instr();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule